// File: doc/BRIEF.md
# Accumulator ALU with Flag Update Masks

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It is purely combinational. It takes a first operand, a second operand, the current carry flag and a four-bit operation code. From these it produces a data result and a set of flag values. Each output comes with its own write strobe, so the surrounding datapath knows exactly what to commit.

Every operation class touches its own subset of the zero (Z), auxiliary-carry (AC) and carry (CY) flags:

- Arithmetic and compare update all three flags.
- The bitwise operations update only Z.
- Increment and decrement keep CY.
- The single-bit rotates change only CY.

Compare produces flags from a subtraction and never asserts the result write strobe. Operand fetch, register addressing and decoding lie outside the block.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) gives result = (a + b) mod 256 and opcode 1 (add with carry) gives (a + b + cin) mod 256. In both cases CY is the carry out of bit 7.
- R2: Opcode 2 (subtract) gives (a - b) mod 256 and opcode 3 (subtract with borrow) gives (a - b - cin) mod 256. In both cases CY is 1 exactly when a < b plus the borrow-in.
- R3: AC is the carry out of bit 3 for add, add with carry and increment. AC is the borrow into bit 3 for subtract, subtract with borrow, compare and decrement.
- R4: Whenever the Z write strobe is high, Z is 1 exactly when the 8-bit result of the operation is 0x00. For compare, this is the discarded difference.
- R5: Opcode 7 (compare) computes a - b and updates Z, AC and CY, with the result write strobe low.
- R6: Opcodes 4, 5 and 6 (AND, OR, XOR) write the bitwise result. They strobe only Z, with the AC and CY strobes low.
- R7: Opcode 8 (increment) gives a + 1 and opcode 9 (decrement) gives a - 1, both wrapping. Both strobe Z and AC and leave the CY strobe low.
- R8: Opcode 10 (rotate right) gives result bit 7 = CY = a[0]. Opcode 11 (rotate left) gives result bit 0 = CY = a[7]. The other bits shift by one place.
- R9: Opcode 12 (rotate right through carry) puts cin into bit 7 and a[0] into CY. Opcode 13 (rotate left through carry) puts cin into bit 0 and a[7] into CY.
- R10: All four rotates write the result and strobe only CY.
- R11: Opcodes 14 and 15 assert no write strobe at all.
- R12: The result write strobe is high for every opcode from 0 to 13 except 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (accumulator side) |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Current carry flag |
| opcode | input | 4 | Operation select, codes 0 to 13 |
| result | output | 8 | Computed data value |
| result_we | output | 1 | Commit strobe for result |
| zero_out | output | 1 | New Z flag value |
| zero_we | output | 1 | Commit strobe for Z |
| aux_out | output | 1 | New AC flag value |
| aux_we | output | 1 | Commit strobe for AC |
| carry_out | output | 1 | New CY flag value |
| carry_we | output | 1 | Commit strobe for CY |

## Verification
The interesting overlap is a wrap to zero that raises Z, AC and CY in the same evaluation. Examples are 0xFF + 0x01 under add, and 0x00 - 0xFF - 1 under subtract with borrow. The bench drives these operand pairs directly. Increment of 0xFF is driven as well: it raises Z and AC together but must keep the CY strobe low. Each output is judged against a bench-side arithmetic model, with a flag value compared only when its strobe is set and every strobe always compared.

// File: rtl/alu8_pkg.sv
// Package: shared opcodes and decode types for the accumulator ALU.
// Assumes a four-bit opcode; codes 14 and 15 are reserved.
package alu8_pkg;

    localparam int OPCODE_W = 4;

    localparam logic [OPCODE_W-1:0] OP_ADD  = 4'd0;
    localparam logic [OPCODE_W-1:0] OP_ADDC = 4'd1;
    localparam logic [OPCODE_W-1:0] OP_SUB  = 4'd2;
    localparam logic [OPCODE_W-1:0] OP_SUBC = 4'd3;
    localparam logic [OPCODE_W-1:0] OP_AND  = 4'd4;
    localparam logic [OPCODE_W-1:0] OP_OR   = 4'd5;
    localparam logic [OPCODE_W-1:0] OP_XOR  = 4'd6;
    localparam logic [OPCODE_W-1:0] OP_CMP  = 4'd7;
    localparam logic [OPCODE_W-1:0] OP_INC  = 4'd8;
    localparam logic [OPCODE_W-1:0] OP_DEC  = 4'd9;
    localparam logic [OPCODE_W-1:0] OP_ROR  = 4'd10;
    localparam logic [OPCODE_W-1:0] OP_ROL  = 4'd11;
    localparam logic [OPCODE_W-1:0] OP_RORC = 4'd12;
    localparam logic [OPCODE_W-1:0] OP_ROLC = 4'd13;

    // Which functional unit feeds the result.
    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_LOGIC = 2'd1,
        SRC_ROT   = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    // Bitwise function select.
    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOP = 2'd3
    } logic_fn_e;

    // Decoded control word.
    typedef struct packed {
        src_e      src;
        logic      subtract;   // arithmetic unit subtracts
        logic      use_cin;    // carry/borrow in taken from carry_in
        logic      unit_b;     // second operand forced to 1 (inc/dec)
        logic_fn_e lfn;
        logic      rot_left;
        logic      rot_thru;   // rotate through carry
        logic      wr_res;
        logic      wr_z;
        logic      wr_ac;
        logic      wr_cy;
    } ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
// Module: alu8_decode
// Turns an opcode into the control word steering the units and the
// write strobes. Assumes reserved opcodes must commit nothing.
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OPCODE_W-1:0] opcode,
    output ctrl_t               ctrl
);

    // Opcode-to-control table, defaults describe a no-op.
    always_comb begin
        ctrl          = '0;
        ctrl.src      = SRC_NONE;
        ctrl.lfn      = LF_NOP;
        case (opcode)
            OP_ADD, OP_ADDC: begin
                ctrl.src     = SRC_ARITH;
                ctrl.use_cin = (opcode == OP_ADDC);
                ctrl.wr_res  = 1'b1;
                ctrl.wr_z    = 1'b1;
                ctrl.wr_ac   = 1'b1;
                ctrl.wr_cy   = 1'b1;
            end
            OP_SUB, OP_SUBC, OP_CMP: begin
                ctrl.src      = SRC_ARITH;
                ctrl.subtract = 1'b1;
                ctrl.use_cin  = (opcode == OP_SUBC);
                ctrl.wr_res   = (opcode != OP_CMP);
                ctrl.wr_z     = 1'b1;
                ctrl.wr_ac    = 1'b1;
                ctrl.wr_cy    = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                ctrl.src    = SRC_LOGIC;
                ctrl.lfn    = (opcode == OP_AND) ? LF_AND :
                              (opcode == OP_OR)  ? LF_OR  : LF_XOR;
                ctrl.wr_res = 1'b1;
                ctrl.wr_z   = 1'b1;
            end
            OP_INC, OP_DEC: begin
                ctrl.src      = SRC_ARITH;
                ctrl.subtract = (opcode == OP_DEC);
                ctrl.unit_b   = 1'b1;
                ctrl.wr_res   = 1'b1;
                ctrl.wr_z     = 1'b1;
                ctrl.wr_ac    = 1'b1;
            end
            OP_ROR, OP_ROL, OP_RORC, OP_ROLC: begin
                ctrl.src      = SRC_ROT;
                ctrl.rot_left = (opcode == OP_ROL) || (opcode == OP_ROLC);
                ctrl.rot_thru = (opcode == OP_RORC) || (opcode == OP_ROLC);
                ctrl.wr_res   = 1'b1;
                ctrl.wr_cy    = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_arith.sv
// Module: alu8_arith
// Adder/subtractor with carry-in or borrow-in. Gives the carry or borrow
// out of the top bit and out of the lower half. Assumes WIDTH is even.
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             half_carry
);

    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] full_w;
    logic [HALF:0]  low_w;
    logic [WIDTH:0] cin_full;
    logic [HALF:0]  cin_low;

    assign cin_full = {{WIDTH{1'b0}}, cin};
    assign cin_low  = {{HALF{1'b0}}, cin};

    // Full-width and lower-half sums; the extra top bit is carry or borrow.
    always_comb begin
        if (subtract) begin
            full_w = {1'b0, a} - {1'b0, b} - cin_full;
            low_w  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - cin_low;
        end else begin
            full_w = {1'b0, a} + {1'b0, b} + cin_full;
            low_w  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + cin_low;
        end
    end

    assign sum        = full_w[WIDTH-1:0];
    assign carry      = full_w[WIDTH];
    assign half_carry = low_w[HALF];

endmodule

// File: rtl/alu8_logic.sv
// Module: alu8_logic
// Bitwise AND/OR/XOR unit, one gate column per bit.
// Assumes the NOP select returns zero.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Per-bit function select.
        always_comb begin
            case (fn)
                LF_AND:  y[i] = a[i] & b[i];
                LF_OR:   y[i] = a[i] | b[i];
                LF_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/alu8_rotate.sv
// Module: alu8_rotate
// Single-place rotate in either direction, either through the carry or
// with the wrapped bit copied into the carry.
module alu8_rotate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    input  logic             left,
    input  logic             thru,
    output logic [WIDTH-1:0] y,
    output logic             cout
);

    logic fill_r;   // bit entering the top on a right rotate
    logic fill_l;   // bit entering the bottom on a left rotate

    assign fill_r = thru ? cin : a[0];
    assign fill_l = thru ? cin : a[WIDTH-1];

    // Shift by one with the chosen fill bit; the bit leaving goes to carry.
    always_comb begin
        if (left) begin
            y    = {a[WIDTH-2:0], fill_l};
            cout = a[WIDTH-1];
        end else begin
            y    = {fill_r, a[WIDTH-1:1]};
            cout = a[0];
        end
    end

endmodule

// File: rtl/alu8_core.sv
// Module: alu8_core (top)
// Combinational ALU for an accumulator machine. Returns a result, the
// Z/AC/CY flag values and one write strobe for each of the four.
// Assumes the caller commits only the strobed outputs.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]    op_a,
    input  logic [WIDTH-1:0]    op_b,
    input  logic                carry_in,
    input  logic [OPCODE_W-1:0] opcode,
    output logic [WIDTH-1:0]    result,
    output logic                result_we,
    output logic                zero_out,
    output logic                zero_we,
    output logic                aux_out,
    output logic                aux_we,
    output logic                carry_out,
    output logic                carry_we
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    ctrl_t            ctrl;
    logic [WIDTH-1:0] arith_b;
    logic             arith_cin;
    logic [WIDTH-1:0] arith_y;
    logic             arith_cy;
    logic             arith_ac;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] rot_y;
    logic             rot_cy;

    alu8_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    assign arith_b   = ctrl.unit_b  ? ONE : op_b;
    assign arith_cin = ctrl.use_cin & carry_in;

    alu8_arith #(.WIDTH(WIDTH)) u_arith (
        .a          (op_a),
        .b          (arith_b),
        .cin        (arith_cin),
        .subtract   (ctrl.subtract),
        .sum        (arith_y),
        .carry      (arith_cy),
        .half_carry (arith_ac)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (op_a),
        .b  (op_b),
        .fn (ctrl.lfn),
        .y  (logic_y)
    );

    alu8_rotate #(.WIDTH(WIDTH)) u_rot (
        .a    (op_a),
        .cin  (carry_in),
        .left (ctrl.rot_left),
        .thru (ctrl.rot_thru),
        .y    (rot_y),
        .cout (rot_cy)
    );

    // Result and carry selection by source unit.
    always_comb begin
        case (ctrl.src)
            SRC_ARITH: begin result = arith_y; carry_out = arith_cy; end
            SRC_LOGIC: begin result = logic_y; carry_out = carry_in; end
            SRC_ROT:   begin result = rot_y;   carry_out = rot_cy;   end
            default:   begin result = op_a;    carry_out = carry_in; end
        endcase
    end

    assign zero_out  = (result == '0);
    assign aux_out   = (ctrl.src == SRC_ARITH) ? arith_ac : 1'b0;
    assign result_we = ctrl.wr_res;
    assign zero_we   = ctrl.wr_z;
    assign aux_we    = ctrl.wr_ac;
    assign carry_we  = ctrl.wr_cy;

endmodule

// File: rtl/alu8_checks.sv
// Module: alu8_checks
// Property checks on the ALU ports, bound to every alu8_core instance.
// Immediate checks only, since the block has no clock.
module alu8_checks
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]    op_a,
    input logic [WIDTH-1:0]    op_b,
    input logic                carry_in,
    input logic [OPCODE_W-1:0] opcode,
    input logic [WIDTH-1:0]    result,
    input logic                result_we,
    input logic                zero_out,
    input logic                zero_we,
    input logic                aux_out,
    input logic                aux_we,
    input logic                carry_out,
    input logic                carry_we
);

    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;

    assign add_ref = {1'b0, op_a} + {1'b0, op_b};
    assign sub_ref = {1'b0, op_a} - {1'b0, op_b};

    // Port-level rules evaluated whenever any input moves.
    always_comb begin
        if (opcode == OP_ADD)
            assert_add_sum_R1: assert ({carry_out, result} == add_ref);
        if (opcode == OP_SUB)
            assert_sub_diff_R2: assert ({carry_out, result} == sub_ref);
        if (opcode == OP_CMP) begin
            assert_cmp_flags_R5: assert (!result_we && zero_we && aux_we && carry_we);
            assert_cmp_zero_R4: assert (zero_out == (op_a == op_b));
        end
        if (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)
            assert_logic_mask_R6: assert (result_we && zero_we && !aux_we && !carry_we);
        if (opcode == OP_INC || opcode == OP_DEC)
            assert_incdec_mask_R7: assert (result_we && zero_we && aux_we && !carry_we);
        if (opcode == OP_ROR)
            assert_ror_wrap_R8: assert (carry_out == op_a[0] && result[WIDTH-1] == op_a[0]);
        if (opcode == OP_ROLC)
            assert_rolc_fill_R9: assert (result[0] == carry_in && carry_out == op_a[WIDTH-1]);
        if (opcode >= OP_ROR && opcode <= OP_ROLC)
            assert_rot_mask_R10: assert (result_we && carry_we && !zero_we && !aux_we);
        if (opcode > OP_ROLC)
            assert_reserved_idle_R11: assert (!result_we && !zero_we && !aux_we && !carry_we);
        if (opcode <= OP_ROLC && opcode != OP_CMP)
            assert_result_we_R12: assert (result_we);
    end

endmodule

bind alu8_core alu8_checks #(.WIDTH(WIDTH)) i_alu8_checks (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .opcode    (opcode),
    .result    (result),
    .result_we (result_we),
    .zero_out  (zero_out),
    .zero_we   (zero_we),
    .aux_out   (aux_out),
    .aux_we    (aux_we),
    .carry_out (carry_out),
    .carry_we  (carry_we)
);

// File: tb/test_alu8_core.sv
// Directed bench for alu8_core: one task per scenario, each checking its
// own vectors against an arithmetic model written from the requirements.
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic       carry_in = 1'b0;
    logic [3:0] opcode = '0;
    logic [7:0] result;
    logic       result_we, zero_out, zero_we, aux_out, aux_we, carry_out, carry_we;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    alu8_core i_alu8_core (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .opcode    (opcode),
        .result    (result),
        .result_we (result_we),
        .zero_out  (zero_out),
        .zero_we   (zero_we),
        .aux_out   (aux_out),
        .aux_we    (aux_we),
        .carry_out (carry_out),
        .carry_we  (carry_we)
    );

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_byte(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Expected outputs from the written requirements.
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input logic c,
                         output logic [7:0] res, output logic wr, output logic z, output logic zw,
                         output logic ac, output logic acw, output logic cy, output logic cyw);
        int s; int lo;
        res = 8'h00; wr = 0; zw = 0; acw = 0; cyw = 0; ac = 0; cy = 0;
        case (op)
            0, 1, 8: begin
                int bb; int cc;
                bb = (op == 8) ? 1 : int'(b);
                cc = (op == 1) ? int'(c) : 0;
                s  = int'(a) + bb + cc;
                lo = int'(a % 16) + (bb % 16) + cc;
                res = s[7:0]; cy = (s > 255); ac = (lo > 15);
                wr = 1; zw = 1; acw = 1; cyw = (op != 8);
            end
            2, 3, 7, 9: begin
                int bb; int cc;
                bb = (op == 9) ? 1 : int'(b);
                cc = (op == 3) ? int'(c) : 0;
                s  = int'(a) - bb - cc;
                lo = int'(a % 16) - (bb % 16) - cc;
                res = s[7:0]; cy = (s < 0); ac = (lo < 0);
                wr = (op != 7); zw = 1; acw = 1; cyw = (op != 9);
            end
            4: begin res = a & b; wr = 1; zw = 1; end
            5: begin res = a | b; wr = 1; zw = 1; end
            6: begin res = a ^ b; wr = 1; zw = 1; end
            10: begin res = {a[0], a[7:1]}; cy = a[0]; wr = 1; cyw = 1; end
            11: begin res = {a[6:0], a[7]}; cy = a[7]; wr = 1; cyw = 1; end
            12: begin res = {c, a[7:1]};    cy = a[0]; wr = 1; cyw = 1; end
            13: begin res = {a[6:0], c};    cy = a[7]; wr = 1; cyw = 1; end
            default: ;
        endcase
        z = (res == 8'h00);
    endtask

    // Drive one vector after a rising edge, judge it at the falling edge.
    task automatic run(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c);
        logic [7:0] er; logic ew, ez, ezw, eac, eacw, ecy, ecyw;
        @(posedge clk); #1;
        opcode = op; op_a = a; op_b = b; carry_in = c;
        @(negedge clk);
        model(op, a, b, c, er, ew, ez, ezw, eac, eacw, ecy, ecyw);
        check_bit(req, "result_we", result_we, ew);
        check_bit(req, "zero_we", zero_we, ezw);
        check_bit(req, "aux_we", aux_we, eacw);
        check_bit(req, "carry_we", carry_we, ecyw);
        if (ew || ezw) check_byte(req, "result", result, er);
        if (ezw)  check_bit(req, "zero", zero_out, ez);
        if (eacw) check_bit(req, "aux", aux_out, eac);
        if (ecyw) check_bit(req, "carry", carry_out, ecy);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check_byte("R4", "idle add result", result, 8'h00);
        check_bit("R4", "idle zero", zero_out, 1'b1);
        check_bit("R12", "idle write", result_we, 1'b1);
    endtask

    task automatic t_add;
        run("R1", 4'd0, 8'h12, 8'h34, 1'b1);
        run("R1", 4'd1, 8'h12, 8'h34, 1'b1);
        run("R3", 4'd0, 8'h0F, 8'h01, 1'b0);
        run("R4", 4'd0, 8'hFF, 8'h01, 1'b0);   // Z, AC, CY together
        run("R1", 4'd1, 8'h7F, 8'h80, 1'b1);
        run("R1", 4'd0, 8'h80, 8'h80, 1'b0);
    endtask

    task automatic t_sub;
        run("R2", 4'd2, 8'h50, 8'h20, 1'b1);
        run("R2", 4'd3, 8'h50, 8'h20, 1'b1);
        run("R3", 4'd2, 8'h10, 8'h01, 1'b0);
        run("R2", 4'd3, 8'h00, 8'hFF, 1'b1);   // Z, AC, CY together
        run("R2", 4'd2, 8'h33, 8'h33, 1'b0);
    endtask

    task automatic t_compare;
        run("R5", 4'd7, 8'h44, 8'h44, 1'b0);
        run("R5", 4'd7, 8'h10, 8'h20, 1'b1);
        run("R5", 4'd7, 8'h80, 8'h01, 1'b0);
    endtask

    task automatic t_logic;
        run("R6", 4'd4, 8'hF0, 8'h0F, 1'b1);
        run("R6", 4'd5, 8'hA0, 8'h05, 1'b1);
        run("R6", 4'd6, 8'h5A, 8'h5A, 1'b0);
    endtask

    task automatic t_incdec;
        run("R7", 4'd8, 8'hFF, 8'h00, 1'b0);
        run("R7", 4'd8, 8'h0F, 8'h00, 1'b1);
        run("R7", 4'd9, 8'h00, 8'h00, 1'b0);
        run("R7", 4'd9, 8'h01, 8'hFF, 1'b1);
    endtask

    task automatic t_rotate;
        run("R8", 4'd10, 8'h01, 8'h00, 1'b0);
        run("R8", 4'd11, 8'h80, 8'h00, 1'b0);
        run("R9", 4'd12, 8'h02, 8'h00, 1'b1);
        run("R9", 4'd13, 8'h40, 8'h00, 1'b1);
        run("R10", 4'd12, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_reserved;
        run("R11", 4'd14, 8'h00, 8'h00, 1'b1);
        run("R11", 4'd15, 8'hFF, 8'hFF, 1'b0);
    endtask

    task automatic t_sweep;
        for (int op = 0; op < 16; op++)
            for (int k = 0; k < 6; k++)
                run("R12", op[3:0], 8'(k * 51 + 3), 8'(k * 37 + 200), k[0]);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add();
        t_sub();
        t_compare();
        t_logic();
        t_incdec();
        t_rotate();
        t_reserved();
        t_sweep();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule